// File: doc/BRIEF.md
# Serial Threshold Offset Loader

This block fills two threshold registers of a FIFO, an empty-side offset and a full-side offset, from a single serial data pin. It runs in the write clock domain. One bit is taken on each rising edge while both active-low controls, the load select and the serial enable, are held low. The bits form one chain. The chain begins at bit 0 of the empty offset, continues through the top bit of the empty offset, and then covers the full offset from bit 0 up to its top bit.

A serial load can be stopped at any bit position by raising either control. The host can then run ordinary FIFO writes. Loading picks up at the next bit in the chain once both controls are low again. The offsets are flagged invalid from the first bit of a chain until its last bit has been captured. The counter then wraps, so any later reprogramming has to shift in the complete chain again.

The register width depends on the bus mode, which is sampled during reset. When both sides run the narrow bus, each offset is one bit wider than in any mode that uses the wide bus. The wide-bus chain is therefore two bits shorter.

Top module: `sofs_loader`

## Requirements
- R1: A serial bit is captured from `ser_in` on a rising `clk` edge only when `ld_n` and `sen_n` are both 0. With `ld_n` at 1, no offset bit changes, whatever `sen_n` is.
- R2: The chain order is fixed. Capture k, counted from 0 after reset or after a wrap, writes `empty_ofs[k]` for k below the register width W. Otherwise it writes `full_ofs[k-W]`. The chain length is 2*W.
- R3: The mode is taken from `cfg_narrow` while `rst` is high. At 1, W = OFS_W_WIDE+1. At 0, W = OFS_W_WIDE, and the top bit of both offset outputs reads 0. Changes on `cfg_narrow` outside reset have no effect.
- R4: When `ld_n` is 0 and `sen_n` is 1, no bit is captured. A pause on either control leaves the offsets unchanged, and the next capture continues at the next bit position.
- R5: `ofs_valid` falls in the cycle after capture 0 of a chain. It stays 0 until the last bit of that chain has been captured.
- R6: After the last capture of a chain, `ofs_valid` is 1 and `prog_done` is 1 for exactly one cycle. The next capture writes `empty_ofs[0]` again.
- R7: Synchronous active-high `rst` clears the bit position and loads DEF_EMPTY and DEF_FULL into the offsets, masked per R3. It also sets `ofs_valid` to 1 and `prog_done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high master reset |
| cfg_narrow | input | 1 | Bus mode, sampled during reset: 1 = narrow on both sides |
| ld_n | input | 1 | Active-low load select |
| sen_n | input | 1 | Active-low serial enable |
| ser_in | input | 1 | Serial offset data |
| empty_ofs | output | OFS_W_WIDE+1 | Empty-side threshold offset |
| full_ofs | output | OFS_W_WIDE+1 | Full-side threshold offset |
| ofs_valid | output | 1 | Offsets hold a complete chain or the reset defaults |
| prog_done | output | 1 | One-cycle pulse after the last bit of a chain |

## Verification
The bench builds the block with OFS_W_WIDE = 4, DEF_EMPTY = 19 and DEF_FULL = 12. This gives a 10-bit chain in narrow mode and an 8-bit chain in wide mode, so many complete chains, wraps and pause patterns fit into a short run. The empty default has bit 4 set, which makes the wide-mode masking of the top bit visible right after reset. The short chains also let every bit position, including both register boundaries and the wrap back to the empty LSB, be hit several times.

// File: rtl/sofs_pkg.sv
package sofs_pkg;

    typedef enum logic {
        MODE_WIDE   = 1'b0,
        MODE_NARROW = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic go;
        logic data;
    } shift_req_t;

    typedef struct packed {
        logic valid;
        logic done;
    } load_status_t;

    function automatic int unsigned reg_bits(input int unsigned wide_w, input bus_mode_e m);
        return (m == MODE_NARROW) ? wide_w + 1 : wide_w;
    endfunction

    function automatic int unsigned chain_bits(input int unsigned wide_w, input bus_mode_e m);
        return 2 * reg_bits(wide_w, m);
    endfunction

endpackage

// File: rtl/sofs_bit_counter.sv
module sofs_bit_counter #(
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] idx,
    output logic             at_first,
    output logic             at_last
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (step) begin
            if (idx_q == last_idx) idx_q <= '0;
            else                   idx_q <= idx_q + 1'b1;
        end
    end

    assign idx      = idx_q;
    assign at_first = (idx_q == '0);
    assign at_last  = (idx_q == last_idx);
endmodule

// File: rtl/sofs_offset_store.sv
module sofs_offset_store #(
    parameter int unsigned OFS_W     = 9,
    parameter int unsigned DEF_EMPTY = 7,
    parameter int unsigned DEF_FULL  = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_go,
    input  logic                     wr_full,
    input  logic [$clog2(OFS_W)-1:0] wr_pos,
    input  logic                     wr_bit,
    input  logic                     narrow,
    output logic [OFS_W-1:0]         empty_o,
    output logic [OFS_W-1:0]         full_o
);
    localparam int unsigned POS_W = $clog2(OFS_W);
    localparam logic [OFS_W-1:0] EMPTY_INIT = OFS_W'(DEF_EMPTY);
    localparam logic [OFS_W-1:0] FULL_INIT  = OFS_W'(DEF_FULL);

    logic [OFS_W-1:0] emp_q, ful_q, hit, fill;

    for (genvar g = 0; g < OFS_W; g++) begin : g_dec
        assign hit[g] = wr_go && (wr_pos == POS_W'(g));
    end

    assign fill = {OFS_W{wr_bit}};

    always_ff @(posedge clk) begin
        if (rst) begin
            emp_q <= EMPTY_INIT;
            ful_q <= FULL_INIT;
        end else if (wr_full) begin
            ful_q <= (ful_q & ~hit) | (fill & hit);
        end else begin
            emp_q <= (emp_q & ~hit) | (fill & hit);
        end
    end

    assign empty_o = {emp_q[OFS_W-1] & narrow, emp_q[OFS_W-2:0]};
    assign full_o  = {ful_q[OFS_W-1] & narrow, ful_q[OFS_W-2:0]};
endmodule

// File: rtl/sofs_loader.sv
module sofs_loader #(
    parameter int unsigned OFS_W_WIDE = 8,
    parameter int unsigned DEF_EMPTY  = 7,
    parameter int unsigned DEF_FULL   = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_narrow,
    input  logic                  ld_n,
    input  logic                  sen_n,
    input  logic                  ser_in,
    output logic [OFS_W_WIDE:0]   empty_ofs,
    output logic [OFS_W_WIDE:0]   full_ofs,
    output logic                  ofs_valid,
    output logic                  prog_done
);
    import sofs_pkg::*;

    localparam int unsigned OFS_W     = OFS_W_WIDE + 1;
    localparam int unsigned CHAIN_MAX = 2 * OFS_W;
    localparam int unsigned IDX_W     = $clog2(CHAIN_MAX);
    localparam int unsigned POS_W     = $clog2(OFS_W);

    bus_mode_e        mode_q;
    shift_req_t       req;
    load_status_t     stat_q;
    logic [IDX_W-1:0] reg_w, last_idx, idx;
    logic             at_first, at_last, sel_full;
    logic [POS_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= cfg_narrow ? MODE_NARROW : MODE_WIDE;
    end

    assign reg_w    = (mode_q == MODE_NARROW) ? IDX_W'(OFS_W) : IDX_W'(OFS_W_WIDE);
    assign last_idx = (reg_w << 1) - 1'b1;

    assign req.go   = !ld_n && !sen_n;
    assign req.data = ser_in;

    sofs_bit_counter #(.IDX_W(IDX_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .step     (req.go),
        .last_idx (last_idx),
        .idx      (idx),
        .at_first (at_first),
        .at_last  (at_last)
    );

    always_comb begin
        sel_full = (idx >= reg_w);
        pos      = sel_full ? POS_W'(idx - reg_w) : POS_W'(idx);
    end

    sofs_offset_store #(
        .OFS_W     (OFS_W),
        .DEF_EMPTY (DEF_EMPTY),
        .DEF_FULL  (DEF_FULL)
    ) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_go   (req.go),
        .wr_full (sel_full),
        .wr_pos  (pos),
        .wr_bit  (req.data),
        .narrow  (mode_q == MODE_NARROW),
        .empty_o (empty_ofs),
        .full_o  (full_ofs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '{valid: 1'b1, done: 1'b0};
        end else begin
            stat_q.done <= req.go && at_last;
            if (req.go && at_last)       stat_q.valid <= 1'b1;
            else if (req.go && at_first) stat_q.valid <= 1'b0;
        end
    end

    assign ofs_valid = stat_q.valid;
    assign prog_done = stat_q.done;
endmodule

// File: rtl/sofs_loader_chk.sv
module sofs_loader_chk #(
    parameter int unsigned OFS_W_WIDE = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_narrow,
    input logic                ld_n,
    input logic                sen_n,
    input logic                ser_in,
    input logic [OFS_W_WIDE:0] empty_ofs,
    input logic [OFS_W_WIDE:0] full_ofs,
    input logic                ofs_valid,
    input logic                prog_done
);
    import sofs_pkg::*;

    bus_mode_e   mode_c;
    int unsigned cap_cnt;
    int unsigned len;
    logic        capture;

    assign capture = !ld_n && !sen_n;
    assign len     = chain_bits(OFS_W_WIDE, mode_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_c  <= cfg_narrow ? MODE_NARROW : MODE_WIDE;
            cap_cnt <= 0;
        end else if (capture) begin
            cap_cnt <= (cap_cnt == len - 1) ? 0 : cap_cnt + 1;
        end
    end

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> ($stable(empty_ofs) && $stable(full_ofs)));

    a_r4_no_capture_sen: assert property (@(posedge clk) disable iff (rst)
        (!ld_n && sen_n) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(ofs_valid)));

    a_r3_top_zero: assert property (@(posedge clk) disable iff (rst)
        (mode_c == MODE_WIDE) |-> (!empty_ofs[OFS_W_WIDE] && !full_ofs[OFS_W_WIDE]));

    a_r5_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(ofs_valid) |-> ($past(capture) && cap_cnt == 1));

    a_r6_done_len: assert property (@(posedge clk) disable iff (rst)
        prog_done |-> (ofs_valid && cap_cnt == 0 && $past(capture) && $past(cap_cnt) == len - 1));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        prog_done |=> !prog_done);

    a_r7_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ofs_valid && !prog_done));
endmodule

bind sofs_loader sofs_loader_chk #(.OFS_W_WIDE(OFS_W_WIDE)) chk_i (.*);

// File: tb/sofs_loader_tb_top.sv
module sofs_loader_tb_top;
    localparam int WW = 4;
    localparam int DE = 19;
    localparam int DF = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_narrow = 1'b1;
    logic ld_n = 1'b1;
    logic sen_n = 1'b1;
    logic ser_in = 1'b0;
    logic [WW:0] empty_ofs, full_ofs;
    logic ofs_valid, prog_done;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    string cur_req = "R7";

    int m_emp, m_ful, m_idx, m_valid, m_done, m_narrow;

    always #2 clk = ~clk;

    sofs_loader #(.OFS_W_WIDE(WW), .DEF_EMPTY(DE), .DEF_FULL(DF)) dut_i (
        .clk(clk), .rst(rst), .cfg_narrow(cfg_narrow), .ld_n(ld_n), .sen_n(sen_n),
        .ser_in(ser_in), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .ofs_valid(ofs_valid), .prog_done(prog_done)
    );

    // behavioural reference
    always @(posedge clk) begin
        if (rst) begin
            m_narrow = int'(cfg_narrow);
            m_emp = DE; m_ful = DF; m_idx = 0; m_valid = 1; m_done = 0;
        end else begin
            m_done = 0;
            if (!ld_n && !sen_n) begin
                int w;
                w = (m_narrow != 0) ? WW + 1 : WW;
                if (m_idx == 0) m_valid = 0;
                if (m_idx < w) m_emp = ser_in ? (m_emp | (1 << m_idx)) : (m_emp & ~(1 << m_idx));
                else           m_ful = ser_in ? (m_ful | (1 << (m_idx - w))) : (m_ful & ~(1 << (m_idx - w)));
                if (m_idx == 2 * w - 1) begin
                    m_valid = 1; m_done = 1; m_idx = 0;
                end else begin
                    m_idx = m_idx + 1;
                end
            end
        end
    end

    function automatic int masked(input int v);
        return (m_narrow != 0) ? (v & 31) : (v & 15);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk(cur_req, int'(empty_ofs), masked(m_emp));
            chk(cur_req, int'(full_ofs), masked(m_ful));
            chk(cur_req, int'(ofs_valid), m_valid);
            chk(cur_req, int'(prog_done), m_done);
        end
    end

    task automatic tick(input logic l, input logic s, input logic d);
        @(negedge clk);
        ld_n = l; sen_n = s; ser_in = d;
    endtask

    task automatic idle();
        tick(1'b1, 1'b1, 1'b0);
    endtask

    task automatic load_seq(input int e, input int f, input int w, input int from, input bit pauses);
        for (int k = from; k < 2 * w; k++) begin
            int b;
            if (pauses && (k % 3 == 1)) begin
                tick(1'b1, 1'b0, 1'b1);
                tick(1'b0, 1'b1, 1'b1);
                tick(1'b1, 1'b1, 1'b0);
            end
            b = (k < w) ? ((e >> k) & 1) : ((f >> (k - w)) & 1);
            tick(1'b0, 1'b0, b[0]);
        end
    endtask

    task automatic do_reset(input logic narrow);
        @(negedge clk);
        rst = 1'b1; cfg_narrow = narrow; ld_n = 1'b1; sen_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        started = 1;
        rst = 1'b0;
        // R7: reset state in narrow mode
        cur_req = "R7";
        chk("R7", int'(empty_ofs), DE);
        chk("R7", int'(full_ofs), DF);
        chk("R7", int'(ofs_valid), 1);
        chk("R7", int'(prog_done), 0);

        // R5: valid drops after first capture
        cur_req = "R5";
        tick(1'b0, 1'b0, 1'b1);
        idle();
        chk("R5", int'(ofs_valid), 0);
        chk("R5", int'(empty_ofs[0]), 1);

        // R2: complete the narrow chain
        cur_req = "R2";
        load_seq(21, 10, WW + 1, 1, 1'b0);
        idle();
        chk("R2", int'(empty_ofs), 21);
        chk("R2", int'(full_ofs), 10);
        chk("R6", int'(prog_done), 1);
        chk("R6", int'(ofs_valid), 1);
        idle();
        chk("R6", int'(prog_done), 0);

        // R1: load select high blocks capture
        cur_req = "R1";
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        idle();
        chk("R1", int'(empty_ofs), 21);
        chk("R1", int'(ofs_valid), 1);

        // R4: paused load with interleaved idle cycles
        cur_req = "R4";
        tick(1'b0, 1'b0, 1'b0);
        tick(1'b0, 1'b1, 1'b1);
        tick(1'b0, 1'b1, 1'b1);
        idle();
        chk("R4", int'(empty_ofs), 20);
        chk("R4", int'(ofs_valid), 0);
        load_seq(28, 19, WW + 1, 1, 1'b1);
        idle();
        chk("R4", int'(empty_ofs), 28);
        chk("R4", int'(full_ofs), 19);
        chk("R4", int'(ofs_valid), 1);

        // R6: wrap goes back to empty LSB
        cur_req = "R6";
        tick(1'b0, 1'b0, 1'b1);
        idle();
        chk("R6", int'(empty_ofs), 29);
        chk("R6", int'(full_ofs), 19);
        load_seq(7, 31, WW + 1, 1, 1'b0);
        idle();
        chk("R6", int'(empty_ofs), 7);
        chk("R6", int'(full_ofs), 31);

        // R3: wide mode, shorter chain and masked top bit
        cur_req = "R3";
        do_reset(1'b0);
        chk("R3", int'(empty_ofs), DE & 15);
        chk("R3", int'(full_ofs), DF);
        cfg_narrow = 1'b1;
        load_seq(9, 6, WW, 0, 1'b0);
        idle();
        chk("R3", int'(empty_ofs), 9);
        chk("R3", int'(full_ofs), 6);
        chk("R3", int'(ofs_valid), 1);
        chk("R3", int'(prog_done), 1);
        load_seq(15, 3, WW, 0, 1'b1);
        idle();
        chk("R3", int'(empty_ofs), 15);
        chk("R3", int'(full_ofs), 3);
        idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule